// File: doc/BRIEF.md
# Masked Four-Lane Vector Arithmetic Unit

This block executes one vector instruction at a time on 64-bit integer elements. The elements are spread over parallel lanes: element n always goes to lane n mod LANES, and a lane never sees another lane's data. Each cycle the unit presents up to one read index per lane to the vector register file. It receives both source elements for that index in the same cycle. One cycle later it returns a write-back result with a per-lane write enable and element index.

Conditional execution uses a per-element mask that the unit keeps between instructions. A not-equal compare against the scalar operand writes the mask. A mask-set instruction turns every bit on. Arithmetic then applies the mask in one of two ways. In sweep mode every element below the vector length is read and computed, and a cleared mask bit only blocks the write. In skip mode each lane walks its own mask bits and spends a cycle only on elements whose bit is set. An instruction with a sparse mask therefore finishes sooner.

Top module: `vmask_alu`

## Requirements
- R1: After reset, busy, done and every write enable are low, and all mask bits are 1.
- R2: Element n is read and written only on lane n mod 4, with rd_idx and wb_idx equal to n. Its result appears on the write-back port in the cycle after its read.
- R3: The opcode values are 0 add (a+b), 1 subtract (a-b), 2 multiply (a*b), 3 scale (a*scalar), 4 compare-not-equal and 5 mask-set. Arithmetic results are the low 64 bits.
- R4: In sweep mode (dense=0), arithmetic reads every element below the vector length. Busy is high for exactly ceil(VL/4) cycles, and only elements whose mask bit is 1 are written.
- R5: In skip mode (dense=1), arithmetic reads only elements whose mask bit is 1, in ascending order within each lane. Busy lasts as many cycles as the largest per-lane count of such elements, which is zero cycles when none exist.
- R6: Compare-not-equal sets mask bit i to (a[i] != scalar) for each i below the vector length and leaves the other bits alone. It writes nothing back and takes ceil(VL/4) busy cycles in either mode.
- R7: Mask-set makes every mask bit 1 with no busy cycles, and done follows in the next cycle.
- R8: The mask keeps its value across arithmetic instructions until a compare or a mask-set changes it.
- R9: A vector length above 64 acts as 64. A length of 0 reads and writes nothing, and done follows in the next cycle.
- R10: A start pulse while busy is high is ignored and does not alter the running instruction or the mask.
- R11: Each instruction raises done for exactly one cycle, while busy is low, in the same cycle as its last write-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue pulse, taken while idle |
| op | input | 3 | Opcode |
| dense | input | 1 | 1 selects skip mode for arithmetic |
| vl | input | 7 | Vector length |
| scalar | input | 64 | Scalar operand |
| rd_vld | output | 4 | Per-lane read request |
| rd_idx | output | 24 | Per-lane element index, 6 bits per lane |
| opa | input | 256 | First source element per lane, same cycle as rd_idx |
| opb | input | 256 | Second source element per lane |
| wb_en | output | 4 | Per-lane write enable |
| wb_idx | output | 24 | Per-lane element index of the write |
| wb_data | output | 256 | Per-lane result |
| busy | output | 1 | Instruction executing |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block at its default configuration: four lanes, 64-bit elements and 64 elements at most. With these values a 16-entry lane slice and every vector length from 0 up to past the clamp can be swept in full. The bench writes whole mask patterns through compares. These include one-lane-only, two-bit sparse and pseudo-random masks, so the skip-mode cycle count can be checked as a per-lane maximum. The results are then checked against arithmetic computed in the bench.

// File: rtl/vmask_pkg.sv
package vmask_pkg;

   typedef enum logic [2:0] {
      OP_ADD   = 3'd0,
      OP_SUB   = 3'd1,
      OP_MUL   = 3'd2,
      OP_MULS  = 3'd3,
      OP_CMPNE = 3'd4,
      OP_MSET  = 3'd5
   } vop_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } vstate_e;

   function automatic logic op_is_arith(input vop_e o);
      return (o == OP_ADD) || (o == OP_SUB) || (o == OP_MUL) || (o == OP_MULS);
   endfunction

endpackage

// File: rtl/vmask_ctrl.sv
module vmask_ctrl
   import vmask_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int ELEM_W = 64,
   parameter int MAX_VL = 64,
   localparam int DEPTH = MAX_VL / LANES,
   localparam int SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int VL_W  = $clog2(MAX_VL + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  vop_e              op_in,
   input  logic              dense_in,
   input  logic [VL_W-1:0]   vl_c,
   input  logic [ELEM_W-1:0] scalar_in,
   input  logic              any_active,
   input  logic [LANES-1:0]  lanes_more,
   output logic              accept,
   output logic              run,
   output logic              dense_run,
   output logic [SW-1:0]     step,
   output logic [VL_W-1:0]   vl_q,
   output vop_e              op_q,
   output logic [ELEM_W-1:0] scalar_q,
   output logic              done
);

   vstate_e     state;
   logic        dense_q;
   logic [SW-1:0] last_q;
   logic        go_run;
   logic        finish;
   logic        arith_in;
   logic        cmp_in;

   assign accept    = start && (state == ST_IDLE);
   assign run       = (state == ST_RUN);
   assign dense_run = dense_q && op_is_arith(op_q);

   always_comb begin
      arith_in = op_is_arith(op_in);
      cmp_in   = (op_in == OP_CMPNE);
      go_run   = (arith_in || cmp_in) && (vl_c != '0)
                 && !(dense_in && arith_in && !any_active);
      finish   = dense_run ? !(|lanes_more) : (step == last_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         dense_q  <= 1'b0;
         last_q   <= '0;
         step     <= '0;
         vl_q     <= '0;
         op_q     <= OP_ADD;
         scalar_q <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (state == ST_IDLE) begin
            if (start) begin
               op_q     <= op_in;
               dense_q  <= dense_in;
               vl_q     <= vl_c;
               scalar_q <= scalar_in;
               last_q   <= SW'((int'(vl_c) - 1) / LANES);
               step     <= '0;
               if (go_run) state <= ST_RUN;
               else        done  <= 1'b1;
            end
         end else begin
            if (finish) begin
               state <= ST_IDLE;
               done  <= 1'b1;
            end else begin
               step <= step + 1'b1;
            end
         end
      end
   end

   // R10: an instruction in flight keeps its latched operation and length
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN) |=> ($stable(op_q) && $stable(vl_q) && $stable(scalar_q)));

   // R4: the sweep counter never passes the final group
   assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && !dense_run) |-> (step <= last_q));

endmodule

// File: rtl/vmask_lane.sv
module vmask_lane
   import vmask_pkg::*;
#(
   parameter int LANES   = 4,
   parameter int LANE_ID = 0,
   parameter int ELEM_W  = 64,
   parameter int MAX_VL  = 64,
   localparam int DEPTH  = MAX_VL / LANES,
   localparam int SW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int PW     = $clog2(DEPTH + 1),
   localparam int IDX_W  = $clog2(MAX_VL),
   localparam int VL_W   = $clog2(MAX_VL + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              load,
   input  logic              dense_mode,
   input  logic [SW-1:0]     step,
   input  logic [VL_W-1:0]   vl_q,
   input  vop_e              op_q,
   input  logic [ELEM_W-1:0] scalar_q,
   input  logic [DEPTH-1:0]  mask_sl,
   input  logic [ELEM_W-1:0] opa,
   input  logic [ELEM_W-1:0] opb,
   output logic              rd_vld,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              more,
   output logic              wb_en,
   output logic [IDX_W-1:0]  wb_idx,
   output logic [ELEM_W-1:0] wb_data,
   output logic              cmp_vld,
   output logic              cmp_bit
);

   logic [DEPTH-1:0]  inr;
   logic [DEPTH-1:0]  cand;
   logic [PW-1:0]     ptr;
   logic [SW-1:0]     first;
   logic              found;
   logic [SW-1:0]     sel;
   logic              sel_ok;
   logic              arith;
   logic [ELEM_W-1:0] result;

   // candidate scan over this lane's slice of the mask
   always_comb begin
      for (int k = 0; k < DEPTH; k++) begin
         inr[k]  = (k * LANES + LANE_ID) < int'(vl_q);
         cand[k] = mask_sl[k] && inr[k] && (PW'(k) >= ptr);
      end
      first = '0;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         if (cand[k]) first = SW'(k);
      end
      found = |cand;
      more  = |(cand & (cand - DEPTH'(1)));
   end

   always_comb begin
      sel     = dense_mode ? first : step;
      sel_ok  = dense_mode ? found : inr[sel];
      rd_vld  = run && sel_ok;
      rd_idx  = IDX_W'(int'(sel) * LANES + LANE_ID);
      arith   = op_is_arith(op_q);
      cmp_vld = rd_vld && (op_q == OP_CMPNE);
      cmp_bit = (opa != scalar_q);
      case (op_q)
         OP_ADD:  result = opa + opb;
         OP_SUB:  result = opa - opb;
         OP_MUL:  result = opa * opb;
         OP_MULS: result = opa * scalar_q;
         default: result = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr     <= '0;
         wb_en   <= 1'b0;
         wb_idx  <= '0;
         wb_data <= '0;
      end else begin
         if (load)
            ptr <= '0;
         else if (run && dense_mode && found)
            ptr <= PW'(first) + 1'b1;
         wb_en <= rd_vld && arith && mask_sl[sel];
         if (rd_vld) begin
            wb_idx  <= rd_idx;
            wb_data <= result;
         end
      end
   end

   // R9: no write lands at or beyond the active vector length
   assert_wb_in_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (int'(wb_idx) < int'(vl_q)));

   // R5: the skip pointer never runs past the lane slice
   assert_ptr_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= PW'(DEPTH));

endmodule

// File: rtl/vmask_alu.sv
module vmask_alu
   import vmask_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int ELEM_W = 64,
   parameter int MAX_VL = 64,
   localparam int DEPTH = MAX_VL / LANES,
   localparam int SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int IDX_W = $clog2(MAX_VL),
   localparam int VL_W  = $clog2(MAX_VL + 1)
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [2:0]              op,
   input  logic                    dense,
   input  logic [VL_W-1:0]         vl,
   input  logic [ELEM_W-1:0]       scalar,
   output logic [LANES-1:0]        rd_vld,
   output logic [LANES*IDX_W-1:0]  rd_idx,
   input  logic [LANES*ELEM_W-1:0] opa,
   input  logic [LANES*ELEM_W-1:0] opb,
   output logic [LANES-1:0]        wb_en,
   output logic [LANES*IDX_W-1:0]  wb_idx,
   output logic [LANES*ELEM_W-1:0] wb_data,
   output logic                    busy,
   output logic                    done
);

   if (LANES < 1 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two");
   end
   if (MAX_VL % LANES != 0 || MAX_VL / LANES < 2) begin : g_bad_len
      $error("MAX_VL must be a multiple of LANES holding at least two per lane");
   end

   logic [MAX_VL-1:0]  mask_q;
   logic [VL_W-1:0]    vl_c;
   logic [MAX_VL-1:0]  in_len;
   logic               any_active;
   logic [DEPTH-1:0]   lmask [LANES];
   logic [LANES-1:0]   lanes_more;
   logic [LANES-1:0]   cmp_vld;
   logic [LANES-1:0]   cmp_bit;
   logic               accept;
   logic               run;
   logic               dense_run;
   logic [SW-1:0]      step;
   logic [VL_W-1:0]    vl_q;
   vop_e               op_q;
   logic [ELEM_W-1:0]  scalar_q;

   always_comb begin
      vl_c = (int'(vl) > MAX_VL) ? VL_W'(MAX_VL) : vl;
      for (int i = 0; i < MAX_VL; i++) in_len[i] = (i < int'(vl_c));
      any_active = |(mask_q & in_len);
      for (int l = 0; l < LANES; l++)
         for (int k = 0; k < DEPTH; k++)
            lmask[l][k] = mask_q[k * LANES + l];
   end

   vmask_ctrl #(.LANES(LANES), .ELEM_W(ELEM_W), .MAX_VL(MAX_VL)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .op_in      (vop_e'(op)),
      .dense_in   (dense),
      .vl_c       (vl_c),
      .scalar_in  (scalar),
      .any_active (any_active),
      .lanes_more (lanes_more),
      .accept     (accept),
      .run        (run),
      .dense_run  (dense_run),
      .step       (step),
      .vl_q       (vl_q),
      .op_q       (op_q),
      .scalar_q   (scalar_q),
      .done       (done)
   );

   assign busy = run;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      vmask_lane #(
         .LANES(LANES), .LANE_ID(g), .ELEM_W(ELEM_W), .MAX_VL(MAX_VL)
      ) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .run        (run),
         .load       (accept),
         .dense_mode (dense_run),
         .step       (step),
         .vl_q       (vl_q),
         .op_q       (op_q),
         .scalar_q   (scalar_q),
         .mask_sl    (lmask[g]),
         .opa        (opa[g*ELEM_W +: ELEM_W]),
         .opb        (opb[g*ELEM_W +: ELEM_W]),
         .rd_vld     (rd_vld[g]),
         .rd_idx     (rd_idx[g*IDX_W +: IDX_W]),
         .more       (lanes_more[g]),
         .wb_en      (wb_en[g]),
         .wb_idx     (wb_idx[g*IDX_W +: IDX_W]),
         .wb_data    (wb_data[g*ELEM_W +: ELEM_W]),
         .cmp_vld    (cmp_vld[g]),
         .cmp_bit    (cmp_bit[g])
      );

      // R4: a write only ever lands where the mask allows it
      assert_wb_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
         wb_en[g] |-> mask_q[wb_idx[g*IDX_W +: IDX_W]]);
   end

   // mask register: set by mask-set, written element-wise by compares
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else begin
         if (accept && vop_e'(op) == OP_MSET) mask_q <= '1;
         for (int l = 0; l < LANES; l++) begin
            if (cmp_vld[l]) mask_q[rd_idx[l*IDX_W +: IDX_W]] <= cmp_bit[l];
         end
      end
   end

   // R11: completion is signalled only once execution has stopped
   assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R7: an accepted mask-set leaves every bit on
   assert_mset_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && vop_e'(op) == OP_MSET) |=> (&mask_q));

   // R8: arithmetic never disturbs the mask
   assert_mask_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && op_is_arith(op_q)) |=> $stable(mask_q));

endmodule

// File: tb/vmask_alu_test.sv
`timescale 1ns/1ps
module vmask_alu_test;

   localparam int L  = 4;
   localparam int W  = 64;
   localparam int MV = 64;
   localparam int IW = 6;
   localparam int VW = 7;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic           rst_n;
   logic           start;
   logic [2:0]     op;
   logic           dense;
   logic [VW-1:0]  vl;
   logic [W-1:0]   scalar;
   logic [L-1:0]   rd_vld;
   logic [L*IW-1:0] rd_idx;
   logic [L*W-1:0] opa;
   logic [L*W-1:0] opb;
   logic [L-1:0]   wb_en;
   logic [L*IW-1:0] wb_idx;
   logic [L*W-1:0] wb_data;
   logic           busy;
   logic           done;

   logic [W-1:0] va [MV];
   logic [W-1:0] vb [MV];

   vmask_alu uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dense(dense),
      .vl(vl), .scalar(scalar), .rd_vld(rd_vld), .rd_idx(rd_idx),
      .opa(opa), .opb(opb), .wb_en(wb_en), .wb_idx(wb_idx),
      .wb_data(wb_data), .busy(busy), .done(done)
   );

   for (genvar g = 0; g < L; g++) begin : g_rf
      assign opa[g*W +: W] = va[rd_idx[g*IW +: IW]];
      assign opb[g*W +: W] = vb[rd_idx[g*IW +: IW]];
   end

   int errs   = 0;
   int checks = 0;
   logic [MV-1:0] rmask;
   logic [W-1:0]  got  [MV];
   bit            gotw [MV];
   int busy_n, reads_n, bad_lane, bad_order, done_n, done_busy, dup_n, extra_done;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic fill(input logic [63:0] seed);
      for (int i = 0; i < MV; i++) begin
         logic [63:0] x;
         x = seed ^ (64'(i + 1) * 64'h9E3779B97F4A7C15);
         va[i] = x ^ (x >> 29);
         vb[i] = (~x) * 64'd3 + 64'(i);
      end
   endtask

   function automatic logic [63:0] expv(input logic [2:0] o, input int i, input logic [63:0] s);
      case (o)
         3'd0: return va[i] + vb[i];
         3'd1: return va[i] - vb[i];
         3'd2: return va[i] * vb[i];
         default: return va[i] * s;
      endcase
   endfunction

   task automatic run_op(input logic [2:0] o, input bit d, input int vlv,
                         input logic [63:0] s, input bit glitch);
      int last [L];
      @(negedge clk);
      op = o; dense = d; vl = VW'(vlv); scalar = s; start = 1'b1;
      for (int i = 0; i < MV; i++) begin gotw[i] = 0; got[i] = '0; end
      for (int l = 0; l < L; l++) last[l] = -1;
      busy_n = 0; reads_n = 0; bad_lane = 0; bad_order = 0;
      done_n = 0; done_busy = 0; dup_n = 0; extra_done = 0;
      for (int c = 0; c < 200; c++) begin
         @(negedge clk);
         start = (glitch && c == 2);
         if (glitch && c == 2) op = 3'd5;
         if (busy) busy_n++;
         for (int l = 0; l < L; l++) begin
            if (rd_vld[l]) begin
               int ix;
               ix = int'(rd_idx[l*IW +: IW]);
               reads_n++;
               if (ix % L != l) bad_lane++;
               if (ix <= last[l]) bad_order++;
               last[l] = ix;
            end
            if (wb_en[l]) begin
               int wx;
               wx = int'(wb_idx[l*IW +: IW]);
               if (wx % L != l) bad_lane++;
               if (gotw[wx]) dup_n++;
               gotw[wx] = 1;
               got[wx]  = wb_data[l*W +: W];
            end
         end
         if (done) begin
            done_n++;
            if (busy) done_busy++;
            break;
         end
      end
      start = 1'b0;
      @(negedge clk);
      if (done) extra_done++;
   endtask

   function automatic int clampv(input int v);
      return (v > MV) ? MV : v;
   endfunction

   task automatic do_arith(input logic [2:0] o, input bit d, input int vlv,
                           input logic [63:0] s, input bit glitch, input string req);
      int vlc, mism, pop, mx, ebusy;
      int cnt [L];
      run_op(o, d, vlv, s, glitch);
      vlc = clampv(vlv);
      mism = 0; pop = 0;
      for (int l = 0; l < L; l++) cnt[l] = 0;
      for (int i = 0; i < MV; i++) begin
         bit ew;
         ew = (i < vlc) && rmask[i];
         if (ew) begin pop++; cnt[i % L]++; end
         if (gotw[i] != ew) mism++;
         else if (ew && got[i] != expv(o, i, s)) mism++;
      end
      mx = 0;
      for (int l = 0; l < L; l++) if (cnt[l] > mx) mx = cnt[l];
      ebusy = d ? mx : (vlc + L - 1) / L;
      chk(mism == 0 && dup_n == 0, req, "write-back set and data mismatches", 64'(mism), 64'd0);
      chk(busy_n == ebusy, d ? "R5" : "R4", "busy cycles", 64'(busy_n), 64'(ebusy));
      chk(reads_n == (d ? pop : vlc), d ? "R5" : "R4", "element reads",
          64'(reads_n), 64'(d ? pop : vlc));
      chk(bad_lane == 0 && bad_order == 0, "R2", "lane mapping or order faults", 64'(bad_lane + bad_order), 64'd0);
      chk(done_n == 1 && done_busy == 0 && extra_done == 0, "R11", "done pulse",
          64'(done_n * 16 + done_busy * 4 + extra_done), 64'd16);
   endtask

   task automatic do_cmp(input int vlv, input logic [63:0] s, input bit d);
      int vlc, wn;
      run_op(3'd4, d, vlv, s, 1'b0);
      vlc = clampv(vlv);
      for (int i = 0; i < vlc; i++) rmask[i] = (va[i] != s);
      wn = 0;
      for (int i = 0; i < MV; i++) if (gotw[i]) wn++;
      chk(wn == 0, "R6", "compare wrote back", 64'(wn), 64'd0);
      chk(busy_n == (vlc + L - 1) / L, "R6", "compare busy cycles", 64'(busy_n), 64'((vlc + L - 1) / L));
      chk(reads_n == vlc, "R6", "compare reads", 64'(reads_n), 64'(vlc));
      chk(done_n == 1 && done_busy == 0 && extra_done == 0, "R11", "compare done pulse",
          64'(done_n), 64'd1);
   endtask

   task automatic set_mask(input logic [63:0] pat, input logic [63:0] s, input bit d);
      for (int i = 0; i < MV; i++) va[i] = pat[i] ? (s ^ 64'(i + 1)) : s;
      do_cmp(MV, s, d);
   endtask

   task automatic do_mset();
      int wn;
      run_op(3'd5, 1'b0, 64, 64'd0, 1'b0);
      rmask = '1;
      wn = 0;
      for (int i = 0; i < MV; i++) if (gotw[i]) wn++;
      chk(busy_n == 0 && wn == 0, "R7", "mask-set busy cycles and writes", 64'(busy_n + wn), 64'd0);
      chk(done_n == 1 && extra_done == 0, "R7", "mask-set done next cycle", 64'(done_n), 64'd1);
   endtask

   initial begin
      #(5.0 * 200000);
      errs++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [63:0] lcg;
      rst_n = 1'b0; start = 1'b0; op = '0; dense = 1'b0; vl = '0; scalar = '0;
      rmask = '1;
      fill(64'h1234);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0 && wb_en == '0, "R1", "reset outputs",
          {60'd0, busy, done, 2'b00} | 64'(wb_en), 64'd0);

      // R1: full write set after reset shows the all-ones mask
      do_arith(3'd0, 1'b0, 64, 64'd0, 1'b0, "R1");

      // R4 R9: sweep every length, including zero and past the clamp
      for (int v = 0; v <= 66; v++) do_arith(3'd0, 1'b0, v, 64'd0, 1'b0, (v == 0 || v > 64) ? "R9" : "R4");
      do_arith(3'd1, 1'b0, 100, 64'd0, 1'b0, "R9");
      do_arith(3'd2, 1'b0, 127, 64'd0, 1'b0, "R9");

      // R3: each arithmetic operation
      for (int o = 0; o < 4; o++) begin
         do_arith(3'(o), 1'b0, 64, 64'hFFFF_FFFF_0000_0007, 1'b0, "R3");
         do_arith(3'(o), 1'b0, 13, 64'h8000_0000_0000_0003, 1'b0, "R3");
      end

      // R6 R8: compare sets a pattern; it persists across later arithmetic
      set_mask(64'hB6DB_6DB6_DB6D_B6DB, 64'h55, 1'b0);
      fill(64'hABCD);
      do_arith(3'd1, 1'b0, 64, 64'd0, 1'b0, "R8");
      do_arith(3'd3, 1'b0, 64, 64'd9, 1'b0, "R8");
      // R5: skip mode over all lengths with this mask
      for (int v = 0; v <= 64; v++) do_arith(3'd2, 1'b1, v, 64'd0, 1'b0, "R5");

      // R5: only lane 1 active, then a two-bit sparse mask
      set_mask(64'h2222_2222_2222_2222, 64'h7, 1'b1);
      fill(64'h77);
      do_arith(3'd0, 1'b1, 64, 64'd0, 1'b0, "R5");
      do_arith(3'd0, 1'b0, 64, 64'd0, 1'b0, "R4");
      set_mask(64'h8000_0000_0000_0001, 64'h7, 1'b0);
      fill(64'h99);
      do_arith(3'd1, 1'b1, 64, 64'd0, 1'b0, "R5");

      // R7 then R6: partial compare leaves bits beyond the length alone
      do_mset();
      do_arith(3'd0, 1'b0, 64, 64'd0, 1'b0, "R7");
      for (int i = 0; i < MV; i++) va[i] = 64'h42;
      do_cmp(20, 64'h42, 1'b1);
      fill(64'h31);
      do_arith(3'd0, 1'b0, 64, 64'd0, 1'b0, "R6");

      // R5: an empty mask in skip mode finishes with no busy cycles
      for (int i = 0; i < MV; i++) va[i] = 64'h5;
      do_cmp(64, 64'h5, 1'b0);
      fill(64'h2);
      do_arith(3'd0, 1'b1, 64, 64'd0, 1'b0, "R5");
      do_arith(3'd2, 1'b0, 64, 64'd0, 1'b0, "R4");

      // R10: a mask-set pulse mid-instruction is ignored
      set_mask(64'h0F0F_3C3C_5A5A_9999, 64'h11, 1'b0);
      fill(64'h44);
      do_arith(3'd1, 1'b0, 64, 64'd0, 1'b1, "R10");
      do_arith(3'd0, 1'b0, 64, 64'd0, 1'b0, "R10");
      do_arith(3'd0, 1'b1, 64, 64'd0, 1'b1, "R10");

      // R5 R4: pseudo-random masks in both modes
      lcg = 64'h0DDB_1A5E_5BAD_5EED;
      for (int t = 0; t < 12; t++) begin
         lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
         set_mask(lcg ^ (lcg << 17), 64'(t), t[0]);
         fill(lcg);
         do_arith(3'(t % 4), 1'b1, 64 - t * 3, 64'(t + 2), 1'b0, "R5");
         do_arith(3'((t + 1) % 4), 1'b0, 40 + t, 64'(t + 5), 1'b0, "R4");
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule